// File: doc/BRIEF.md
# Pilot-Tone Timing-Recovery Loop with Rotor and Sample-Slip Control

This block closes the timing-recovery loop of a multicarrier receiver. The sampling clocks at the two ends of the line are never exactly equal, so the pilot tone drifts in phase from one symbol to the next. Once per symbol an upstream detector presents a signed measure of that drift. The block passes it through a proportional-plus-integral loop filter. The integrator value is the estimate of the frequency offset, and it is driven out for any logic that needs it.

The block also keeps an accumulated phase. Each accepted measurement adds the current frequency estimate and the proportional term to that phase. While the phase stays within half a sample period, its value goes to a downstream frequency-domain rotor as the rotation angle. When it moves past that bound, the block pulses a request to the sample front end to drop or repeat one sample. In the same update it removes one sample period of phase from the accumulator, so the angle given to the rotor is the value after the slip.

A freeze input holds the loop, for example while the front end is being retrained. The loop gains are power-of-two shifts that can be changed at run time.

Top module: `timing_loop_dpll`

## Requirements
- R1: While `rst_n` is low at a clock edge, the frequency estimate and rotor angle become 0 and both strobes become 0.
- R2: An accepted update (`pe_valid` high and `freeze` low at a clock edge) adds `pe_err >>> ki_shift` to the frequency estimate. The shift is arithmetic, so it rounds toward minus infinity. The sum saturates at the signed range of `FRQ_W` bits instead of wrapping.
- R3: An accepted update forms a candidate phase: the stored phase, plus the frequency estimate as it was before this update, plus `pe_err >>> kp_shift`. The candidate saturates at the signed range of `ACC_W` bits.
- R4: If the candidate is greater than +SLIP_STEP/2, `del_strobe` is 1 for the cycle after the edge, and SLIP_STEP is subtracted from the stored phase.
- R5: If the candidate is less than −SLIP_STEP/2, `ins_strobe` is 1 for the cycle after the edge, and SLIP_STEP is added to the stored phase.
- R6: At most one slip is made per update, so the two strobes are never high together. `rot_angle` shows the stored phase after any slip, in the cycle following the edge.
- R7: While `freeze` is high, `pe_valid` is ignored: the frequency estimate and rotor angle keep their values and both strobes are 0.
- R8: In a cycle without an accepted update, both strobes are 0 and the estimate and angle do not change, so each strobe lasts exactly one cycle.
- R9: When the candidate lies between −SLIP_STEP/2 and +SLIP_STEP/2 inclusive, no strobe is raised and `rot_angle` equals the candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pe_valid | input | 1 | Phase-error measurement valid, once per symbol |
| pe_err | input | PH_W | Signed pilot phase error, full scale ±π |
| freeze | input | 1 | Hold the loop state and ignore measurements |
| kp_shift | input | SH_W | Right shift that sets the proportional gain |
| ki_shift | input | SH_W | Right shift that sets the integral gain |
| freq_est | output | FRQ_W | Signed frequency-offset estimate (integrator) |
| rot_angle | output | ACC_W | Signed rotation angle for the rotor, same units as the phase error |
| ins_strobe | output | 1 | One-cycle request to insert one sample |
| del_strobe | output | 1 | One-cycle request to delete one sample |

## Verification
The assertions assume the following about the inputs: `FRQ_W` is at least `PH_W`, `ACC_W` is at least `FRQ_W`, and SLIP_STEP is a positive even number well inside the accumulator range. Under those conditions a single slip always brings a candidate at the bound back across zero, and a rotor angle that follows an update without a slip always lies within ±SLIP_STEP/2. The stimulus uses only the default widths and step. It draws the error, the shifts, the valid and the freeze from a seeded generator. Directed runs then hold a full-scale error with a zero integral shift until both the integrator and the accumulator reach their saturation limits. Other directed runs set the candidate exactly on each half-step bound and one unit past it.

// File: rtl/tl_pkg.sv
// Shared types for the timing-recovery loop.
// Assumes nothing beyond the users importing it.
package tl_pkg;
    // Outcome of the slip decision made on one accepted update.
    typedef enum logic [1:0] {
        SLIP_NONE = 2'b00,
        SLIP_INS  = 2'b01,
        SLIP_DEL  = 2'b10
    } slip_e;
endpackage

// File: rtl/tl_loop_filter.sv
// Integral branch of the loop filter: it scales the phase error by a
// power-of-two shift and adds it to a saturating integrator, which is
// the frequency-offset estimate.
// Assumes FRQ_W >= PH_W and that upd is already qualified by freeze.
module tl_loop_filter #(
    parameter int PH_W  = 16,
    parameter int FRQ_W = 20,
    parameter int SH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [PH_W-1:0]  err,
    input  logic [SH_W-1:0]         ki_sh,
    output logic signed [FRQ_W-1:0] freq_q
);
    localparam int EW = FRQ_W + 2;
    localparam logic signed [EW-1:0] FMAX = EW'((64'sd1 <<< (FRQ_W-1)) - 1);
    localparam logic signed [EW-1:0] FMIN = -FMAX - 1;

    logic signed [EW-1:0] err_ext;
    logic signed [EW-1:0] inc;
    logic signed [EW-1:0] sum;
    logic signed [FRQ_W-1:0] freq_d;

    // Scale the error and form the saturated next integrator value.
    always_comb begin
        err_ext = EW'(err);
        inc     = err_ext >>> ki_sh;
        sum     = EW'(freq_q) + inc;
        if (sum > FMAX)      freq_d = FRQ_W'(FMAX);
        else if (sum < FMIN) freq_d = FRQ_W'(FMIN);
        else                 freq_d = FRQ_W'(sum);
    end

    // Integrator register: cleared by reset, loaded on accepted updates.
    always_ff @(posedge clk) begin
        if (!rst_n)   freq_q <= '0;
        else if (upd) freq_q <= freq_d;
    end

    // R8 R7: the integrator moves only on an accepted update.
    assert_freq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(freq_q));
endmodule

// File: rtl/tl_slip_ctrl.sv
// Slip decision: compares a candidate phase with plus or minus half a
// sample period, and returns the slip kind and the phase after the slip.
// Purely combinational. Assumes SLIP_STEP is even, positive and small
// against the accumulator range.
module tl_slip_ctrl
    import tl_pkg::*;
#(
    parameter int ACC_W     = 20,
    parameter int SLIP_STEP = 4096
) (
    input  logic signed [ACC_W-1:0] cand,
    output slip_e                   kind,
    output logic signed [ACC_W-1:0] post
);
    localparam int EW = ACC_W + 2;
    localparam logic signed [EW-1:0] HALF = EW'(SLIP_STEP / 2);
    localparam logic signed [EW-1:0] STEP = EW'(SLIP_STEP);

    logic signed [EW-1:0] c_ext;

    // Choose at most one slip and correct the phase by one sample period.
    always_comb begin
        c_ext = EW'(cand);
        if (c_ext > HALF) begin
            kind = SLIP_DEL;
            post = ACC_W'(c_ext - STEP);
        end else if (c_ext < -HALF) begin
            kind = SLIP_INS;
            post = ACC_W'(c_ext + STEP);
        end else begin
            kind = SLIP_NONE;
            post = cand;
        end
    end
endmodule

// File: rtl/tl_phase_acc.sv
// Phase accumulator: forms the candidate phase from the stored phase,
// the frequency estimate and the proportional term, saturates it, applies
// the slip decision and registers the phase and the slip strobes.
// Assumes ACC_W >= FRQ_W >= PH_W and an upd already qualified by freeze.
module tl_phase_acc
    import tl_pkg::*;
#(
    parameter int PH_W      = 16,
    parameter int FRQ_W     = 20,
    parameter int ACC_W     = 20,
    parameter int SH_W      = 4,
    parameter int SLIP_STEP = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [PH_W-1:0]  err,
    input  logic [SH_W-1:0]         kp_sh,
    input  logic signed [FRQ_W-1:0] freq,
    output logic signed [ACC_W-1:0] phase_q,
    output logic                    ins_q,
    output logic                    del_q
);
    localparam int EW = ACC_W + 2;
    localparam logic signed [EW-1:0] AMAX = EW'((64'sd1 <<< (ACC_W-1)) - 1);
    localparam logic signed [EW-1:0] AMIN = -AMAX - 1;
    localparam logic signed [EW-1:0] HALF = EW'(SLIP_STEP / 2);

    logic signed [EW-1:0]    prop;
    logic signed [EW-1:0]    sum;
    logic signed [ACC_W-1:0] cand;
    logic signed [ACC_W-1:0] post;
    slip_e                   kind;

    // Proportional term plus frequency step, saturated to the phase range.
    always_comb begin
        prop = EW'(err) >>> kp_sh;
        sum  = EW'(phase_q) + EW'(freq) + prop;
        if (sum > AMAX)      cand = ACC_W'(AMAX);
        else if (sum < AMIN) cand = ACC_W'(AMIN);
        else                 cand = ACC_W'(sum);
    end

    tl_slip_ctrl #(
        .ACC_W     (ACC_W),
        .SLIP_STEP (SLIP_STEP)
    ) slip_i (
        .cand (cand),
        .kind (kind),
        .post (post)
    );

    // Phase register: loads the phase after the slip on accepted updates.
    always_ff @(posedge clk) begin
        if (!rst_n)   phase_q <= '0;
        else if (upd) phase_q <= post;
    end

    // Strobe registers: one-cycle pulses, only after an accepted update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_q <= 1'b0;
            del_q <= 1'b0;
        end else begin
            ins_q <= upd && (kind == SLIP_INS);
            del_q <= upd && (kind == SLIP_DEL);
        end
    end

    // R6: never both slip requests at once.
    assert_one_slip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_q && del_q));
    // R8: no strobe and no phase change without an accepted update.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> (!ins_q && !del_q && $stable(phase_q)));
    // R4: after a delete, the stored phase lies above minus half a step.
    assert_del_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        del_q |-> (EW'(phase_q) > -HALF));
    // R5: after an insert, the stored phase lies below plus half a step.
    assert_ins_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_q |-> (EW'(phase_q) < HALF));
    // R9: an update without a slip leaves the phase within the half-step bounds.
    assert_noslip_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (ins_q || del_q || (EW'(phase_q) <= HALF && EW'(phase_q) >= -HALF)));
endmodule

// File: rtl/timing_loop_dpll.sv
// Top of the timing-recovery loop. It qualifies each measurement with
// freeze, feeds the integral branch and the phase accumulator, and drives
// the frequency estimate, the rotor angle and the slip strobes.
// Assumes one pe_valid per symbol and ACC_W >= FRQ_W >= PH_W.
module timing_loop_dpll #(
    parameter int PH_W      = 16,
    parameter int FRQ_W     = 20,
    parameter int ACC_W     = 20,
    parameter int SH_W      = 4,
    parameter int SLIP_STEP = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pe_valid,
    input  logic signed [PH_W-1:0]  pe_err,
    input  logic                    freeze,
    input  logic [SH_W-1:0]         kp_shift,
    input  logic [SH_W-1:0]         ki_shift,
    output logic signed [FRQ_W-1:0] freq_est,
    output logic signed [ACC_W-1:0] rot_angle,
    output logic                    ins_strobe,
    output logic                    del_strobe
);
    logic upd;
    logic signed [FRQ_W-1:0] freq_w;

    // Accept a measurement only while the loop is not frozen.
    always_comb upd = pe_valid && !freeze;

    tl_loop_filter #(
        .PH_W  (PH_W),
        .FRQ_W (FRQ_W),
        .SH_W  (SH_W)
    ) filt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd),
        .err    (pe_err),
        .ki_sh  (ki_shift),
        .freq_q (freq_w)
    );

    tl_phase_acc #(
        .PH_W      (PH_W),
        .FRQ_W     (FRQ_W),
        .ACC_W     (ACC_W),
        .SH_W      (SH_W),
        .SLIP_STEP (SLIP_STEP)
    ) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .err     (pe_err),
        .kp_sh   (kp_shift),
        .freq    (freq_w),
        .phase_q (rot_angle),
        .ins_q   (ins_strobe),
        .del_q   (del_strobe)
    );

    always_comb freq_est = freq_w;

    // R7: a frozen cycle leaves the estimate and the angle unchanged.
    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(freq_est) && $stable(rot_angle) && !ins_strobe && !del_strobe));
endmodule

// File: tb/timing_loop_dpll_tb_top.sv
`timescale 1ns/1ps
module timing_loop_dpll_tb_top;
    localparam int PH_W = 16, FRQ_W = 20, ACC_W = 20, SH_W = 4, STEP = 4096;
    localparam longint FMAX = (64'sd1 <<< (FRQ_W-1)) - 1;
    localparam longint AMAX = (64'sd1 <<< (ACC_W-1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pe_valid = 1'b0;
    logic signed [PH_W-1:0] pe_err = '0;
    logic freeze = 1'b0;
    logic [SH_W-1:0] kp_shift = '0, ki_shift = '0;
    logic signed [FRQ_W-1:0] freq_est;
    logic signed [ACC_W-1:0] rot_angle;
    logic ins_strobe, del_strobe;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    longint m_f = 0, m_p = 0;
    bit m_ins = 0, m_del = 0;

    always #2.5 clk = ~clk;

    timing_loop_dpll #(.PH_W(PH_W), .FRQ_W(FRQ_W), .ACC_W(ACC_W), .SH_W(SH_W),
                       .SLIP_STEP(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .pe_valid(pe_valid), .pe_err(pe_err),
        .freeze(freeze), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .freq_est(freq_est), .rot_angle(rot_angle),
        .ins_strobe(ins_strobe), .del_strobe(del_strobe));

    function automatic longint sat(longint v, longint mx);
        if (v > mx) return mx;
        if (v < -mx - 1) return -mx - 1;
        return v;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, step the model, then compare after the edge.
    task automatic step(bit v, int e, bit frz, int kp, int ki, string req);
        longint cand;
        pe_valid = v; pe_err = PH_W'(e); freeze = frz;
        kp_shift = SH_W'(kp); ki_shift = SH_W'(ki);
        m_ins = 0; m_del = 0;
        if (v && !frz) begin
            cand = sat(m_p + m_f + (longint'(e) >>> kp), AMAX);
            m_f = sat(m_f + (longint'(e) >>> ki), FMAX);
            if (cand > STEP/2) begin m_del = 1; cand -= STEP; end
            else if (cand < -STEP/2) begin m_ins = 1; cand += STEP; end
            m_p = cand;
        end
        @(negedge clk);
        check({req, " freq"}, longint'(freq_est), m_f);
        check({req, " angle"}, longint'(rot_angle), m_p);
        check({req, " ins"}, longint'(ins_strobe), longint'(m_ins));
        check({req, " del"}, longint'(del_strobe), longint'(m_del));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pe_valid = 0; freeze = 0;
        @(negedge clk); @(negedge clk);
        m_f = 0; m_p = 0;
        check("R1 freq", longint'(freq_est), 0);
        check("R1 angle", longint'(rot_angle), 0);
        check("R1 strobes", longint'(ins_strobe | del_strobe), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        @(negedge clk);
        do_reset();
        // R9 R4 R5 R6: candidate exactly on the bounds and one unit past them.
        step(1, 2048, 0, 0, 15, "R9 upper bound");
        do_reset();
        step(1, 2049, 0, 0, 15, "R4 delete");
        do_reset();
        step(1, -2048, 0, 0, 14, "R9 lower bound");
        do_reset();
        step(1, -2049, 0, 0, 14, "R5 insert");
        step(0, 0, 0, 0, 0, "R8 strobe one cycle");
        // R7: freeze ignores valid data.
        step(1, 20000, 1, 0, 0, "R7 freeze");
        step(1, -20000, 1, 3, 3, "R7 freeze");
        step(0, 30000, 0, 0, 0, "R8 no valid");
        // R2 R3: saturate the integrator and the accumulator.
        for (int i = 0; i < 40; i++) step(1, 32767, 0, 0, 0, "R2 R3 positive saturation");
        check("R2 freq at max", longint'(freq_est), FMAX);
        for (int i = 0; i < 80; i++) step(1, -32768, 0, 0, 0, "R2 R3 negative saturation");
        check("R2 freq at min", longint'(freq_est), -FMAX - 1);
        do_reset();
        // R10-free random mix of shifts, errors, valid and freeze (R2 R3 R4 R5 R6 R7 R8).
        for (int i = 0; i < 3000; i++) begin
            int e, kp, ki;
            bit v, f;
            e  = int'($signed(16'($urandom)));
            kp = int'($urandom_range(15, 0));
            ki = int'($urandom_range(15, 4));
            v  = ($urandom_range(3, 0) != 0);
            f  = ($urandom_range(9, 0) == 0);
            step(v, e, f, kp, ki, "R3 random");
            if (i % 500 == 499) do_reset();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule